// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of an I/O-mapped peripheral cluster. A host sees two byte-wide I/O addresses: an index port and, one address above it, a data port. After reset the port is locked. The host unlocks it by writing a fixed four-byte key to the index port. After that it selects a register by writing its number to the index port, and then reads or writes that register through the data port. A two-step exit command locks the port again.

Registers fall into two spaces. The global space holds the logical-device selector, a read-only 16-bit chip identifier and a revision nibble. The device space (indices 0x30 and up) belongs to whichever logical device the selector names. The block itself keeps an enable bit and a 16-bit base address for each logical device and drives them out as ports. Every other device-space index is passed to an external register-file port, tagged with the selected device number and the index, so the logical devices can hold their own registers there.

Top module: `keyed_cfg_port`

## Requirements
- R1: Reset leaves the port locked, with logical device 0 selected and the index register at 0x00, and with every device enable bit and base address at zero.
- R2: Writing the bytes 0x87, 0x01, 0x55, 0x55 to the index port, in that order, unlocks the port. While unlocked, an index-port read returns the current index. While locked, it returns 0xFF.
- R3: Any index write that does not match the next expected key byte restarts the match. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, data-port writes have no effect, data-port reads return 0xFF, and index-port writes only feed the key matcher and leave the index register unchanged.
- R5: While unlocked, a data write of 0x02 with the index at 0x02 locks the port. A data write of any other value at index 0x02 has no effect.
- R6: Index 0x20 reads the high byte of the CHIP_ID parameter, index 0x21 reads its low byte, and index 0x22 reads {4'h0, CHIP_REV}. Writes to these indices have no effect.
- R7: Index 0x07 is the logical device selector. It is read/write across its full 8 bits and decides which device the device-space indices reach.
- R8: For a selected device below NUM_DEV, index 0x30 bit 0 is that device's enable bit. It drives dev_active[device], and it reads back as {7'h0, bit}.
- R9: For a selected device below NUM_DEV, index 0x60 holds the high byte and index 0x61 the low byte of that device's base address, driven on dev_base[16*device +: 16].
- R10: A data access to an index at or above 0x30, other than 0x30, 0x60 and 0x61, is passed to the external port. A write raises ext_wr for one cycle with ext_ldn, ext_idx and ext_wdata set. A read returns ext_rdata. Other unassigned global indices below 0x30 read 0x00.
- R11: The index register keeps its value across data accesses, so repeated data reads after one index write all reach the same register.
- R12: io_rdata is registered. It takes the value of a port read at the clock edge that samples io_rd, and it holds that value until the next port read.
- R13: When the selector is NUM_DEV or higher, indices 0x30, 0x60 and 0x61 read 0x00 and writes to them change no device state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device |
| ext_wr | output | 1 | Write strobe to the external device registers |
| ext_rd | output | 1 | Read strobe to the external device registers |
| ext_ldn | output | 8 | Selected logical device for the external access |
| ext_idx | output | 8 | Register index for the external access |
| ext_wdata | output | 8 | Write data for the external access |
| ext_rdata | input | 8 | Combinational read data from the external device registers |

## Verification
The bench builds the port with its default parameters: index port 0x2E, four logical devices, chip ID 0x8716 and revision 3. With four devices, the random selector values from 0 to 5 reach both the internal enable and base storage of every device and the out-of-range selectors 4 and 5, which must read zero and change nothing. The key matcher is driven with directed partial, broken and overlapping key strings, so the restart rule on a stray 0x87 is exercised. The default chip ID checks that the two identifier bytes come out in the right order.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int KEY_LEN = 4;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_CTRL  = 8'h02;
  localparam logic [7:0] EXIT_VAL  = 8'h02;
  localparam logic [7:0] IDX_IDHI  = 8'h20;
  localparam logic [7:0] IDX_IDLO  = 8'h21;
  localparam logic [7:0] IDX_REV   = 8'h22;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_BASEH = 8'h60;
  localparam logic [7:0] IDX_BASEL = 8'h61;
  localparam logic [7:0] DEV_SPACE = 8'h30;

  function automatic logic [7:0] key_byte(input logic [2:0] pos);
    case (pos)
      3'd0:    key_byte = 8'h87;
      3'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_in,
  input  logic       relock,
  output logic       unlocked
);
  localparam int STEP_W = $clog2(KEY_LEN + 1);
  localparam logic [STEP_W-1:0] DONE = STEP_W'(KEY_LEN);

  logic [STEP_W-1:0] step_q;

  assign unlocked = (step_q == DONE);

  always_ff @(posedge clk) begin
    if (rst || relock) begin
      step_q <= '0;
    end else if (key_wr && !unlocked) begin
      if (key_in == key_byte(3'(step_q)))
        step_q <= step_q + 1'b1;
      else if (key_in == key_byte(3'd0))
        step_q <= STEP_W'(1);
      else
        step_q <= '0;
    end
  end

  // R2: the port opens only on the last key byte
  p_unlock_on_key_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && key_in == 8'h55));

  // R5: relock always lands in the locked state
  p_relock_closes_r5: assert property (@(posedge clk) disable iff (rst)
    relock |=> !unlocked);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [7:0]           idx,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [NUM_DEV-1:0]   dev_active,
  output logic [16*NUM_DEV-1:0] dev_base,
  output logic                 ext_wr,
  output logic                 ext_rd,
  output logic [7:0]           ext_ldn,
  output logic [7:0]           ext_idx,
  output logic [7:0]           ext_wdata,
  input  logic [7:0]           ext_rdata
);
  logic [7:0]  ldn_q;
  logic        act_q  [NUM_DEV];
  logic [15:0] base_q [NUM_DEV];

  logic is_dev, is_int;
  assign is_dev = (idx >= DEV_SPACE);
  assign is_int = (idx == IDX_ACT) || (idx == IDX_BASEH) || (idx == IDX_BASEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        act_q[d]  <= 1'b0;
        base_q[d] <= '0;
      end
    end else if (wr_en) begin
      if (idx == IDX_LDN) ldn_q <= wdata;
      for (int d = 0; d < NUM_DEV; d++) begin
        if (ldn_q == 8'(d)) begin
          if (idx == IDX_ACT)   act_q[d]        <= wdata[0];
          if (idx == IDX_BASEH) base_q[d][15:8] <= wdata;
          if (idx == IDX_BASEL) base_q[d][7:0]  <= wdata;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev_out
    assign dev_active[g]         = act_q[g];
    assign dev_base[16*g +: 16]  = base_q[g];
  end

  assign ext_wr    = wr_en && is_dev && !is_int;
  assign ext_rd    = rd_en && is_dev && !is_int;
  assign ext_ldn   = ldn_q;
  assign ext_idx   = idx;
  assign ext_wdata = wdata;

  always_comb begin
    rdata = 8'h00;
    if (idx == IDX_LDN)        rdata = ldn_q;
    else if (idx == IDX_IDHI)  rdata = CHIP_ID[15:8];
    else if (idx == IDX_IDLO)  rdata = CHIP_ID[7:0];
    else if (idx == IDX_REV)   rdata = {4'h0, CHIP_REV};
    else if (is_int) begin
      for (int d = 0; d < NUM_DEV; d++) begin
        if (ldn_q == 8'(d)) begin
          if (idx == IDX_ACT)        rdata = {7'h0, act_q[d]};
          else if (idx == IDX_BASEH) rdata = base_q[d][15:8];
          else                       rdata = base_q[d][7:0];
        end
      end
    end else if (is_dev)       rdata = ext_rdata;
  end

  // R4: device state moves only on an accepted data write
  p_state_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(dev_active) && $stable(dev_base)));

  // R13: out-of-range selector leaves device state untouched
  p_oob_ldn_inert_r13: assert property (@(posedge clk) disable iff (rst)
    (ldn_q >= 8'(NUM_DEV)) |=> ($stable(dev_active) && $stable(dev_base)));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(16'h002E),
  parameter int          NUM_DEV  = 4,
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter logic [3:0]  CHIP_REV = 4'h3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic                  io_rd,
  input  logic                  io_wr,
  input  logic [7:0]            io_wdata,
  output logic [7:0]            io_rdata,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_base,
  output logic                  ext_wr,
  output logic                  ext_rd,
  output logic [7:0]            ext_ldn,
  output logic [7:0]            ext_idx,
  output logic [7:0]            ext_wdata,
  input  logic [7:0]            ext_rdata
);
  localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + 1'b1;

  logic       hit_idx, hit_data, unlocked, exit_cmd;
  logic [7:0] index_q, rf_rdata;

  assign hit_idx  = (io_addr == IDX_PORT);
  assign hit_data = (io_addr == DATA_PORT);
  assign exit_cmd = io_wr && hit_data && unlocked &&
                    (index_q == IDX_CTRL) && (io_wdata == EXIT_VAL);

  cfg_key_fsm i_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (io_wr && hit_idx),
    .key_in   (io_wdata),
    .relock   (exit_cmd),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst)                                 index_q <= '0;
    else if (io_wr && hit_idx && unlocked)   index_q <= io_wdata;
  end

  cfg_regfile #(
    .NUM_DEV  (NUM_DEV),
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) i_rf (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (io_wr && hit_data && unlocked),
    .rd_en      (io_rd && hit_data && unlocked),
    .idx        (index_q),
    .wdata      (io_wdata),
    .rdata      (rf_rdata),
    .dev_active (dev_active),
    .dev_base   (dev_base),
    .ext_wr     (ext_wr),
    .ext_rd     (ext_rd),
    .ext_ldn    (ext_ldn),
    .ext_idx    (ext_idx),
    .ext_wdata  (ext_wdata),
    .ext_rdata  (ext_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)                        io_rdata <= 8'hFF;
    else if (io_rd && hit_idx)      io_rdata <= unlocked ? index_q : 8'hFF;
    else if (io_rd && hit_data)     io_rdata <= unlocked ? rf_rdata : 8'hFF;
  end

  // R4: locked data reads float high
  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (rst)
    (io_rd && hit_data && !unlocked) |=> (io_rdata == 8'hFF));

  // R10: nothing reaches the device registers while locked
  p_ext_needs_unlock_r10: assert property (@(posedge clk) disable iff (rst)
    (ext_wr || ext_rd) |-> unlocked);

  // R12: read data holds between port reads
  p_rdata_holds_r12: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && (hit_idx || hit_data)) |=> $stable(io_rdata));

  // R4: locked index writes never move the index
  p_locked_index_r4: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(index_q));
endmodule

// File: tb/test_keyed_cfg_port.sv
module test_keyed_cfg_port;
  localparam int NDEV = 4;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [NDEV-1:0]    dev_active;
  logic [16*NDEV-1:0] dev_base;
  logic        ext_wr, ext_rd;
  logic [7:0]  ext_ldn, ext_idx, ext_wdata, ext_rdata;

  int checks = 0, errors = 0;
  logic [7:0] last_ldn, last_idx, last_dat;
  int ext_wr_cnt = 0;

  bit        m_act  [8];
  logic [15:0] m_base [8];
  logic [7:0]  m_ldn;

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_ext(input logic [7:0] l, input logic [7:0] i);
    return l ^ {i[6:0], 1'b1};
  endfunction
  assign ext_rdata = exp_ext(ext_ldn, ext_idx);

  always @(posedge clk) if (ext_wr) begin
    last_ldn <= ext_ldn; last_idx <= ext_idx; last_dat <= ext_wdata;
    ext_wr_cnt <= ext_wr_cnt + 1;
  end

  keyed_cfg_port i_keyed_cfg_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_active(dev_active),
    .dev_base(dev_base), .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_ldn(ext_ldn),
    .ext_idx(ext_idx), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic unlock();
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(IDXP, i); wr(DATP, d);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(IDXP, i); rd(DATP, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int d = 0; d < 8; d++) begin m_act[d] = 0; m_base[d] = '0; end
    m_ldn = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R4: reset state is locked
    rd(DATP, v); chk("R1 locked data read", v, 8'hFF);
    rd(IDXP, v); chk("R2 locked index read", v, 8'hFF);
    chk("R1 reset dev_active", dev_active, '0);
    chk("R1 reset dev_base", dev_base, '0);
    wr(DATP, 8'h33);
    unlock();
    rd(IDXP, v); chk("R1 reset index", v, 8'h00);
    reg_rd(8'h07, v); chk("R1 reset ldn", v, 8'h00);

    // R5 exit, and non-exit value at index 0x02
    reg_wr(8'h02, 8'h01);
    rd(IDXP, v); chk("R5 non-exit stays open", v, 8'h02);
    wr(DATP, 8'h02);
    rd(DATP, v); chk("R5 exit relocks data", v, 8'hFF);
    rd(IDXP, v); chk("R5 exit relocks index", v, 8'hFF);

    // R4: locked writes do nothing
    wr(IDXP, 8'h07); wr(DATP, 8'h03);
    unlock();
    rd(IDXP, v); chk("R4 locked index write ignored", v, 8'h02);
    reg_rd(8'h07, v); chk("R4 locked data write ignored", v, 8'h00);
    reg_wr(8'h02, 8'h02);

    // R3: broken and overlapping keys
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h11);
    wr(IDXP, 8'h55);
    rd(DATP, v); chk("R3 broken key stays locked", v, 8'hFF);
    wr(IDXP, 8'h87); wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    rd(IDXP, v); chk("R3 repeated first byte unlocks", v, 8'h02);
    reg_wr(8'h02, 8'h02);
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h87);
    wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    rd(IDXP, v); chk("R3 stray 0x87 restarts match", v, 8'h02);

    // R6: identification
    reg_rd(8'h20, v); chk("R6 id high", v, 8'h87);
    reg_rd(8'h21, v); chk("R6 id low", v, 8'h16);
    reg_rd(8'h22, v); chk("R6 revision", v, 8'h03);
    reg_wr(8'h21, 8'h00);
    rd(DATP, v); chk("R6 id read-only", v, 8'h16);

    // R7: selector full width
    reg_wr(8'h07, 8'hA2); rd(DATP, v); chk("R7 ldn readback", v, 8'hA2);
    m_ldn = 8'hA2;

    // R8 / R9 / R13: random device traffic
    for (int n = 0; n < 60; n++) begin
      logic [7:0] l, d, i;
      int op;
      l = 8'($urandom_range(0, 5));
      d = 8'($urandom);
      op = $urandom_range(0, 2);
      i = (op == 0) ? 8'h30 : (op == 1) ? 8'h60 : 8'h61;
      reg_wr(8'h07, l); m_ldn = l;
      reg_wr(i, d);
      if (l < NDEV) begin
        if (op == 0) m_act[l] = d[0];
        else if (op == 1) m_base[l][15:8] = d;
        else m_base[l][7:0] = d;
      end
      rd(DATP, v);
      if (l >= NDEV) chk("R13 oob ldn reads zero", v, 8'h00);
      else if (op == 0) chk("R8 act readback", v, {7'h0, m_act[l]});
      else if (op == 1) chk("R9 base hi readback", v, m_base[l][15:8]);
      else chk("R9 base lo readback", v, m_base[l][7:0]);
      for (int k = 0; k < NDEV; k++) begin
        chk("R8 dev_active port", dev_active[k], m_act[k]);
        chk("R9 dev_base port", dev_base[16*k +: 16], m_base[k]);
      end
    end

    // R10: external register file
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h45, 8'h3C);
    chk("R10 ext write count", ext_wr_cnt, 1);
    chk("R10 ext ldn", last_ldn, 8'h01);
    chk("R10 ext idx", last_idx, 8'h45);
    chk("R10 ext data", last_dat, 8'h3C);
    reg_rd(8'hF0, v); chk("R10 ext read", v, exp_ext(8'h01, 8'hF0));
    reg_rd(8'h10, v); chk("R10 unassigned global", v, 8'h00);
    reg_wr(8'h30, 8'h01);
    chk("R10 internal not forwarded", ext_wr_cnt, 1);

    // R11: index held across reads
    reg_wr(8'h60, 8'h5A);
    for (int r = 0; r < 3; r++) begin
      rd(DATP, v); chk("R11 repeated read", v, 8'h5A);
    end

    // R12: read data registered and held
    @(negedge clk); io_addr = IDXP; io_rd = 1'b1;
    #2 chk("R12 not before edge", io_rdata, 8'h5A);
    @(negedge clk); io_rd = 1'b0;
    chk("R12 after edge", io_rdata, 8'h60);
    wr(IDXP, 8'h20);
    @(negedge clk);
    chk("R12 holds without read", io_rdata, 8'h60);

    // R1: reset again restores defaults
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears active", dev_active, '0);
    rd(DATP, v); chk("R1 relocked by reset", v, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule